// File: doc/BRIEF.md
# I2C SCL Period Generator

This block times the SCL line for an I2C master. A 12-bit divider is assembled from two 8-bit control bytes. The lower byte carries seven divider bits and a speed-mode bit; the upper byte supplies the five high divider bits. The mode bit selects how the divider is turned into a clock period. Standard mode splits the period roughly evenly between the low and high phases. Fast mode makes the low phase about twice as long as the high phase.

The byte controller raises `run_i` to request clock pulses. It gets a one-cycle strobe when SCL is pulled low and another when SCL is let go. A level output drives the open-drain pull-down. After each release, the sensed SCL level is watched. A slave that holds the line low extends the high phase by the number of cycles it holds it.

The divider and the mode are sampled once per period, at the start of the low phase. A control write made during a period therefore changes only the periods that follow.

Top module: `scl_clk_gen`

## Requirements
- R1: After reset, `scl_pull_o`, `scl_low_stb_o` and `scl_rel_stb_o` are all 0.
- R2: The divider is CC = {`clk_ext_i`[4:0], `clk_ctl_i`[6:0]}. Bits 7:5 of `clk_ext_i` have no effect on timing.
- R3: When `clk_ctl_i`[7] = 0 (standard mode), each period drives SCL low for CC+3 cycles and releases it for CC+2 cycles, a total of 2·CC+5.
- R4: When `clk_ctl_i`[7] = 1 (fast mode), each period drives SCL low for 2·CC+4 cycles and releases it for CC+2 cycles, a total of 3·CC+6.
- R5: A divider value of 0 or 1 gives the same timing as a value of 2.
- R6: Divider and mode are captured in the first cycle of the low phase. A change made during a period takes effect from the next period onward.
- R7: During the high phase, each cycle in which SCL is sensed low after release adds one cycle to the high phase.
- R8: `scl_low_stb_o` is 1 exactly in the first cycle of each low phase. `scl_rel_stb_o` is 1 exactly in the first cycle of each high phase. The two strobes are never 1 together.
- R9: While `run_i` is 0, the current period runs to completion and SCL then stays released. Raising `run_i` from idle starts a low phase in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Request continuous SCL pulses |
| clk_ctl_i | input | 8 | Bit 7 selects fast mode; bits 6:0 are the divider low bits |
| clk_ext_i | input | 8 | Bits 4:0 are divider bits 11:7; bits 7:5 are ignored |
| scl_i | input | 1 | Sensed SCL level |
| scl_pull_o | output | 1 | 1 = drive SCL low |
| scl_low_stb_o | output | 1 | One-cycle pulse at the start of each low phase |
| scl_rel_stb_o | output | 1 | One-cycle pulse at the start of each high phase |

## Verification
The divider is swept from 0 through 24 in both modes, which separates the two per-mode formulas and exercises the clamp at values 0 and 1. The all-ones divider in each mode checks the upper five bits and the 14-bit length arithmetic. A value with bits 7:5 of the upper byte set must give the same timing as the same divider without them.

The control bytes change in the first cycle of every period, so each measured period must still show the previous setting. A jump from a small to the largest divider checks this deferral where the difference is easiest to see. Stretches of 1 to 3 cycles must lengthen only the high phase. Dropping `run_i` must leave SCL released for a long stretch afterwards.

// File: rtl/scl_gen_pkg.sv
`timescale 1ns/1ps
package scl_gen_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  typedef enum logic {
    SCL_STD  = 1'b0,
    SCL_FAST = 1'b1
  } scl_mode_e;
endpackage

// File: rtl/scl_div_decode.sv
`timescale 1ns/1ps
module scl_div_decode
  import scl_gen_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int CC_LO_W = 7,
  parameter int CC_HI_W = 5,
  parameter int CC_MIN  = 2,
  parameter int LEN_W   = 14
) (
  input  logic [REG_W-1:0] ctl_i,
  input  logic [REG_W-1:0] ext_i,
  output logic [LEN_W-1:0] low_len_o,
  output logic [LEN_W-1:0] high_len_o
);
  localparam int DIV_W = CC_LO_W + CC_HI_W;

  logic [DIV_W-1:0] cc, cc_eff;
  scl_mode_e mode;
  logic [REG_W-CC_HI_W-1:0] unused_ext;

  assign unused_ext = ext_i[REG_W-1:CC_HI_W];
  assign cc     = {ext_i[CC_HI_W-1:0], ctl_i[CC_LO_W-1:0]};
  assign mode   = scl_mode_e'(ctl_i[REG_W-1]);
  assign cc_eff = (cc < DIV_W'(CC_MIN)) ? DIV_W'(CC_MIN) : cc;

  assign high_len_o = LEN_W'(cc_eff) + LEN_W'(2);

  always_comb begin
    if (mode == SCL_FAST) low_len_o = (LEN_W'(cc_eff) << 1) + LEN_W'(4);
    else                  low_len_o = LEN_W'(cc_eff) + LEN_W'(3);
  end
endmodule

// File: rtl/scl_in_sync.sv
`timescale 1ns/1ps
module scl_in_sync #(
  parameter int STAGES = 0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  output logic scl_o
);
  generate
    if (STAGES == 0) begin : g_direct
      assign scl_o = scl_i;
    end else begin : g_flops
      logic [STAGES-1:0] sync_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[STAGES-2 >= 0 ? STAGES-2 : 0:0], scl_i};
      end
      assign scl_o = sync_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/scl_phase_timer.sv
`timescale 1ns/1ps
module scl_phase_timer
  import scl_gen_pkg::*;
#(
  parameter int LEN_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             scl_high_i,
  input  logic [LEN_W-1:0] low_len_i,
  input  logic [LEN_W-1:0] high_len_i,
  output logic             pull_o,
  output logic             low_stb_o,
  output logic             rel_stb_o
);
  scl_phase_e       st_q;
  logic [LEN_W-1:0] cnt_q, hi_q;
  logic             pull_q, lstb_q, rstb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      hi_q   <= '0;
      pull_q <= 1'b0;
      lstb_q <= 1'b0;
      rstb_q <= 1'b0;
    end else begin
      lstb_q <= 1'b0;
      rstb_q <= 1'b0;
      unique case (st_q)
        PH_IDLE: begin
          if (run_i) begin
            st_q   <= PH_LOW;
            pull_q <= 1'b1;
            lstb_q <= 1'b1;
            cnt_q  <= low_len_i - LEN_W'(1);
            hi_q   <= high_len_i;
          end
        end
        PH_LOW: begin
          if (cnt_q == '0) begin
            st_q   <= PH_HIGH;
            pull_q <= 1'b0;
            rstb_q <= 1'b1;
            cnt_q  <= hi_q - LEN_W'(1);
          end else begin
            cnt_q <= cnt_q - LEN_W'(1);
          end
        end
        PH_HIGH: begin
          // count only while the line is really high (stretch support)
          if (scl_high_i) begin
            if (cnt_q == '0) begin
              if (run_i) begin
                st_q   <= PH_LOW;
                pull_q <= 1'b1;
                lstb_q <= 1'b1;
                cnt_q  <= low_len_i - LEN_W'(1);
                hi_q   <= high_len_i;
              end else begin
                st_q <= PH_IDLE;
              end
            end else begin
              cnt_q <= cnt_q - LEN_W'(1);
            end
          end
        end
        default: st_q <= PH_IDLE;
      endcase
    end
  end

  assign pull_o    = pull_q;
  assign low_stb_o = lstb_q;
  assign rel_stb_o = rstb_q;

  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_HIGH && !scl_high_i) |=> (st_q == PH_HIGH && $stable(cnt_q))); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PH_IDLE) |-> !pull_o); // R9
  AST_LOW_STB_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_stb_o |-> (pull_o && !$past(pull_o))); // R8
  AST_REL_STB_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_stb_o |-> (!pull_o && $past(pull_o))); // R8
  AST_LOW_LONGER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_len_i > high_len_i); // R3
endmodule

// File: rtl/scl_clk_gen.sv
`timescale 1ns/1ps
module scl_clk_gen #(
  parameter int REG_W       = 8,
  parameter int CC_LO_W     = 7,
  parameter int CC_HI_W     = 5,
  parameter int CC_MIN      = 2,
  parameter int SYNC_STAGES = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [REG_W-1:0] clk_ctl_i,
  input  logic [REG_W-1:0] clk_ext_i,
  input  logic             scl_i,
  output logic             scl_pull_o,
  output logic             scl_low_stb_o,
  output logic             scl_rel_stb_o
);
  localparam int DIV_W = CC_LO_W + CC_HI_W;
  localparam int LEN_W = DIV_W + 2;

  logic [LEN_W-1:0] low_len, high_len;
  logic             scl_sensed;

  scl_div_decode #(
    .REG_W(REG_W), .CC_LO_W(CC_LO_W), .CC_HI_W(CC_HI_W),
    .CC_MIN(CC_MIN), .LEN_W(LEN_W)
  ) u_dec (
    .ctl_i      (clk_ctl_i),
    .ext_i      (clk_ext_i),
    .low_len_o  (low_len),
    .high_len_o (high_len)
  );

  scl_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .scl_i  (scl_i),
    .scl_o  (scl_sensed)
  );

  scl_phase_timer #(.LEN_W(LEN_W)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_i),
    .scl_high_i (scl_sensed),
    .low_len_i  (low_len),
    .high_len_i (high_len),
    .pull_o     (scl_pull_o),
    .low_stb_o  (scl_low_stb_o),
    .rel_stb_o  (scl_rel_stb_o)
  );

  AST_STB_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(scl_low_stb_o && scl_rel_stb_o)); // R8
  AST_HIGH_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_len >= LEN_W'(CC_MIN + 2)); // R5
endmodule

// File: tb/sim_scl_clk_gen.sv
`timescale 1ns/1ps
module sim_scl_clk_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       run_i = 1'b0;
  logic [7:0] ctl = 8'h00;
  logic [7:0] ext = 8'h00;
  logic       hold = 1'b0;
  logic       scl_i;
  logic       pull, lstb, rstb;

  int n_chk = 0;
  int n_fail = 0;
  bit cur_f;
  int cur_cc;
  bit cur_junk;

  assign scl_i = !pull && !hold;

  always #2.5 clk = ~clk;

  scl_clk_gen u0 (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i),
    .clk_ctl_i(ctl), .clk_ext_i(ext), .scl_i(scl_i),
    .scl_pull_o(pull), .scl_low_stb_o(lstb), .scl_rel_stb_o(rstb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clamp(input int cc);
    return (cc < 2) ? 2 : cc;
  endfunction

  function automatic int exp_low(input bit f, input int cc);
    return f ? 2 * clamp(cc) + 4 : clamp(cc) + 3;
  endfunction

  function automatic int exp_high(input int cc);
    return clamp(cc) + 2;
  endfunction

  // entered at the negedge of the first low cycle; leaves at the next one
  task automatic get_period(input int s, output int l, output int h, output bit ok);
    l = 0; h = 0; ok = 1'b1;
    while (pull) begin
      l++;
      if (l == 1 && !lstb) ok = 1'b0;
      if (l > 1 && (lstb || rstb)) ok = 1'b0;
      @(negedge clk);
    end
    while (!pull) begin
      h++;
      hold = (h <= s);
      if (h == 1 && !rstb) ok = 1'b0;
      if (h > 1 && (lstb || rstb)) ok = 1'b0;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic step(input bit f, input int cc, input bit junk, input int s,
                      input string force_tag);
    int l, h, el, eh;
    bit ok;
    string tag;
    ctl = {f, 7'(cc)};
    ext = {(junk ? 3'b101 : 3'b000), 5'(cc >> 7)};
    get_period(s, l, h, ok);
    el = exp_low(cur_f, cur_cc);
    eh = exp_high(cur_cc) + s;
    if (force_tag != "")  tag = force_tag;
    else if (cur_cc < 2)  tag = "R5";
    else if (cur_junk)    tag = "R2";
    else if (cur_f)       tag = "R4";
    else                  tag = "R3";
    chk(l == el, tag, l, el);
    chk(h == eh, (s > 0) ? "R7" : tag, h, eh);
    chk(ok, "R8", int'(ok), 1);
    cur_f = f; cur_cc = cc; cur_junk = junk;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int idle_bad;
    repeat (4) @(negedge clk);
    chk(!pull && !lstb && !rstb, "R1", int'({pull, lstb, rstb}), 0);
    rst_ni = 1'b1;
    repeat (6) @(negedge clk);
    chk(!pull, "R9", int'(pull), 0);

    // first period: standard, CC = 5
    ctl = 8'h05; ext = 8'h00;
    cur_f = 1'b0; cur_cc = 5; cur_junk = 1'b0;
    run_i = 1'b1;
    @(negedge clk);
    chk(pull && lstb, "R9", int'(pull), 1);

    for (int i = 0; i <= 24; i++) step(1'b0, i, 1'b0, 0, "");
    for (int i = 0; i <= 24; i++) step(1'b1, i, 1'b0, 0, "");
    step(1'b0, 469, 1'b1, 0, "");
    step(1'b0, 469, 1'b0, 0, "");   // measures 469 with bits 7:5 set
    step(1'b1, 3, 1'b0, 0, "");     // measures 469 plain
    step(1'b1, 4095, 1'b0, 0, "R6"); // still fast 3 while 4095 pending
    step(1'b0, 4095, 1'b0, 0, "");
    step(1'b0, 6, 1'b0, 0, "");
    for (int s = 1; s <= 3; s++) step(1'b0, 6, 1'b0, s, "");
    step(1'b1, 6, 1'b0, 0, "");
    for (int s = 1; s <= 3; s++) step(1'b1, 6, 1'b0, s, "");

    // stop: current period finishes, then SCL stays released
    run_i = 1'b0;
    while (pull) @(negedge clk);
    idle_bad = 0;
    repeat (60) begin
      if (pull || lstb) idle_bad++;
      @(negedge clk);
    end
    chk(idle_bad == 0, "R9", idle_bad, 0);
    run_i = 1'b1;
    @(negedge clk);
    chk(pull && lstb, "R9", int'(pull), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule